// File: doc/BRIEF.md
# PDM Microphone CIC Decimator

This block converts the one-bit pulse-density stream of a digital microphone into signed 16-bit PCM words at 48 kHz. The whole block runs in a single 100 MHz system-clock domain. It makes the 3.072 MHz microphone bit clock itself, from a fractional phase accumulator, so the bit clock and the sample timing keep an exact long-term ratio to the system clock and never drift.

Once per bit period, on the rising edge of the bit clock it drives out, the block takes the data line through a two-flop synchronizer. It maps the bit to +1 or −1 and feeds it into five running-sum integrators. Every 64 bits, a chain of five difference stages takes the last integrator value. The top 16 bits of the difference result go to the output register, together with a valid strobe one system cycle wide. All arithmetic is two's complement and wraps. Because the differences cancel the wrap, an integrator that overflows still gives the correct output.

The block is meant to sit next to the microphone pins. Its output goes straight into any consumer that accepts one word per strobe.

Top module: `mic_cic_top`

## Requirements
- R1: `micClk` is low in reset. After reset, consecutive rising edges of `micClk` are always 32 or 33 system cycles apart.
- R2: Exactly 480 rising edges of `micClk` fall within the first 15625 system cycles after reset is released. This is the exact rate 3.072 MHz / 100 MHz.
- R3: `sampleValid` is a pulse one system cycle wide. Consecutive pulses are 2083 or 2084 system cycles apart, which is one pulse per 64 bit periods.
- R4: Any three consecutive intervals between `sampleValid` pulses add up to exactly 6250 system cycles. The output rate therefore has no long-term error.
- R5: `sampleOut` is two's complement, and a data bit of 1 counts as +1. A steady all-ones input settles to 16384 (0x4000). A steady all-zeros input settles to −16384 (0xC000).
- R6: A repeating input whose ones and zeros are balanced (1010 or 1100) settles to exactly 0.
- R7: A repeating 4-bit input with three ones (1110) settles to 8192 (0x2000). A repeating 4-bit input with one one (1000) settles to −8192 (0xE000).
- R8: `sampleOut` changes only in the cycle in which `sampleValid` is high. Between pulses it holds its value.
- R9: A synchronous reset clears the output word to 0, holds `sampleValid` and `micClk` low, and restarts the decimation count. The first pulse after release comes about 64 bit periods later (2060 to 2080 cycles).
- R10: A sustained full-scale input, which makes the internal sums wrap many times, still gives the exact settled value on every later sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (100 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| pdmData | input | 1 | Raw microphone data line |
| micClk | output | 1 | Generated microphone bit clock |
| sampleOut | output | OUT_W | Decimated PCM word, two's complement |
| sampleValid | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench drives repeating 4-bit patterns, changing the data line on the falling edge of the generated bit clock. For each pattern it checks the settled word against the duty-cycle value; an error in scaling, in the sign mapping or in the stage count moves these values. A design that drops or adds one bit per frame, or that rounds the bit-clock divider to an integer, fails the exact edge count and the three-interval sum of 6250 cycles. A design without wrap-around arithmetic loses the full-scale value after the sums overflow. A reset issued while the block runs checks that the clock, the strobe and the output word all clear, and that the frame count restarts from zero.

// File: rtl/mic_cic_pkg.sv
package mic_cic_pkg;

  // Strobes from the timing control to the filter datapath.
  typedef struct packed {
    logic sampleEn;  // take one input bit this cycle
    logic dumpEn;    // this bit closes a decimation frame
  } cic_strobe_t;

endpackage

// File: rtl/mic_cic_ctrl.sv
module mic_cic_ctrl
  import mic_cic_pkg::*;
#(
  parameter int SYS_HZ = 100_000_000,
  parameter int BIT_HZ = 3_072_000,
  parameter int DECIM  = 64
) (
  input  logic        clk,
  input  logic        rst,
  output logic        micClk,
  output cic_strobe_t strobe
);

  localparam int ACC_W = $clog2(SYS_HZ) + 1;
  localparam int CNT_W = $clog2(DECIM);
  localparam logic [ACC_W:0] INC_V = (ACC_W + 1)'(2 * BIT_HZ);
  localparam logic [ACC_W:0] LIM_V = (ACC_W + 1)'(SYS_HZ);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DECIM - 1);
  localparam int GAP_LO = SYS_HZ / BIT_HZ;
  localparam int GAP_HI = GAP_LO + 1;

  logic [ACC_W-1:0] phaseAcc;
  logic [ACC_W:0]   phaseSum;
  logic             phaseWrap;
  logic [CNT_W-1:0] bitCnt;

  // Half-period phase accumulator: every wrap toggles the bit clock.
  always_comb begin
    phaseSum  = {1'b0, phaseAcc} + INC_V;
    phaseWrap = (phaseSum >= LIM_V);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseAcc <= '0;
      micClk   <= 1'b0;
      bitCnt   <= '0;
      strobe   <= '0;
    end else begin
      strobe.sampleEn <= 1'b0;
      strobe.dumpEn   <= 1'b0;
      if (phaseWrap) begin
        phaseAcc <= ACC_W'(phaseSum - LIM_V);
        micClk   <= ~micClk;
        if (!micClk) begin
          // Rising edge of the bit clock: sample the data line.
          strobe.sampleEn <= 1'b1;
          strobe.dumpEn   <= (bitCnt == LAST_BIT);
          bitCnt          <= (bitCnt == LAST_BIT) ? '0 : bitCnt + 1'b1;
        end
      end else begin
        phaseAcc <= ACC_W'(phaseSum);
      end
    end
  end

  // Checker state: cycles since the previous sample strobe.
  logic [15:0] gapCnt;
  logic        seenRise;
  always_ff @(posedge clk) begin
    if (rst) begin
      gapCnt   <= '0;
      seenRise <= 1'b0;
    end else if (strobe.sampleEn) begin
      gapCnt   <= 16'd1;
      seenRise <= 1'b1;
    end else if (gapCnt != '1) begin
      gapCnt <= gapCnt + 16'd1;
    end
  end

  p_bitclk_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (strobe.sampleEn && seenRise) |-> (gapCnt == 16'(GAP_LO) || gapCnt == 16'(GAP_HI)));

  p_sample_on_high_r1: assert property (@(posedge clk) disable iff (rst)
    strobe.sampleEn |-> micClk);

  p_phase_bound_r2: assert property (@(posedge clk) disable iff (rst)
    {1'b0, phaseAcc} < LIM_V);

  p_dump_with_sample_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.dumpEn |-> strobe.sampleEn);

endmodule

// File: rtl/mic_cic_datapath.sv
module mic_cic_datapath
  import mic_cic_pkg::*;
#(
  parameter int STAGES = 5,
  parameter int DECIM  = 64,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pdmData,
  input  cic_strobe_t       strobe,
  output logic [OUT_W-1:0]  sampleOut,
  output logic              sampleValid
);

  // One guard bit beyond the gain so that full-scale +1 input fits.
  localparam int ACC_W = 2 + STAGES * $clog2(DECIM);
  localparam int SHIFT = ACC_W - OUT_W;

  logic [1:0]              syncQ;
  logic signed [ACC_W-1:0] stepVal;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '0;
    else     syncQ <= {syncQ[0], pdmData};
  end

  assign stepVal = syncQ[1] ? ACC_W'(1) : '1;

  // Integrator chain, advanced once per bit.
  for (genvar g = 0; g < STAGES; g++) begin : intStg
    logic signed [ACC_W-1:0] q;
    logic signed [ACC_W-1:0] addend;
    if (g == 0) begin : gFirst
      assign addend = stepVal;
    end else begin : gNext
      assign addend = intStg[g-1].q;
    end
    always_ff @(posedge clk) begin
      if (rst)                  q <= '0;
      else if (strobe.sampleEn) q <= q + addend;
    end
  end

  // Comb chain, advanced once per frame.
  for (genvar g = 0; g < STAGES; g++) begin : cmbStg
    logic signed [ACC_W-1:0] din;
    logic signed [ACC_W-1:0] dly;
    logic signed [ACC_W-1:0] diff;
    if (g == 0) begin : gFirst
      assign din = intStg[STAGES-1].q;
    end else begin : gNext
      assign din = cmbStg[g-1].diff;
    end
    assign diff = din - dly;
    always_ff @(posedge clk) begin
      if (rst)                dly <= '0;
      else if (strobe.dumpEn) dly <= din;
    end
  end

  logic signed [ACC_W-1:0] scaled;
  assign scaled = cmbStg[STAGES-1].diff >>> SHIFT;

  always_ff @(posedge clk) begin
    if (rst) begin
      sampleOut   <= '0;
      sampleValid <= 1'b0;
    end else begin
      sampleValid <= strobe.dumpEn;
      if (strobe.dumpEn) sampleOut <= OUT_W'(scaled);
    end
  end

  p_valid_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    sampleValid |=> !sampleValid);

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$stable(sampleOut) |-> sampleValid);

  p_valid_after_dump_r3: assert property (@(posedge clk) disable iff (rst)
    sampleValid |-> $past(strobe.dumpEn));

endmodule

// File: rtl/mic_cic_top.sv
module mic_cic_top
  import mic_cic_pkg::*;
#(
  parameter int SYS_HZ = 100_000_000,
  parameter int BIT_HZ = 3_072_000,
  parameter int STAGES = 5,
  parameter int DECIM  = 64,
  parameter int OUT_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pdmData,
  output logic             micClk,
  output logic [OUT_W-1:0] sampleOut,
  output logic             sampleValid
);

  cic_strobe_t strobe;

  mic_cic_ctrl #(
    .SYS_HZ(SYS_HZ),
    .BIT_HZ(BIT_HZ),
    .DECIM (DECIM)
  ) uCtrl (
    .clk   (clk),
    .rst   (rst),
    .micClk(micClk),
    .strobe(strobe)
  );

  mic_cic_datapath #(
    .STAGES(STAGES),
    .DECIM (DECIM),
    .OUT_W (OUT_W)
  ) uPath (
    .clk        (clk),
    .rst        (rst),
    .pdmData    (pdmData),
    .strobe     (strobe),
    .sampleOut  (sampleOut),
    .sampleValid(sampleValid)
  );

endmodule

// File: tb/tb_mic_cic_top.sv
`timescale 1ns/1ps
module tb_mic_cic_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pdmData = 1'b0;
  logic        micClk;
  logic [15:0] sampleOut;
  logic        sampleValid;

  mic_cic_top dut (
    .clk(clk), .rst(rst), .pdmData(pdmData),
    .micClk(micClk), .sampleOut(sampleOut), .sampleValid(sampleValid)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Repeating 4-bit input pattern, advanced on each falling bit-clock edge.
  logic [3:0] pattern = 4'b1111;
  logic [1:0] phase = 2'd0;
  always @(negedge micClk) begin
    pdmData <= pattern[3 - phase];
    phase   <= phase + 2'd1;
  end

  // Port monitor.
  int  cyc = 0;
  bit  prevClk = 0;
  int  lastRise = -1;
  int  badClk = 0;
  int  risesWin = 0;
  bit  firstRun = 1;
  int  validCount = 0;
  logic [15:0] lastSample = '0;
  logic [15:0] prevOut = '0;
  int  lastValid = -1;
  int  firstValidCyc = -1;
  int  iv0 = 0, iv1 = 0, iv2 = 0, ivN = 0;
  int  badGap = 0, badSum = 0, badHold = 0, badWidth = 0;
  bit  prevValid = 0;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; prevClk = 0; lastRise = -1; lastValid = -1;
      firstValidCyc = -1; ivN = 0; prevValid = 0;
      prevOut = sampleOut;
    end else begin
      cyc++;
      if (micClk && !prevClk) begin
        if (lastRise >= 0 && (cyc - lastRise) != 32 && (cyc - lastRise) != 33) badClk++;
        lastRise = cyc;
        if (firstRun && cyc <= 15625) risesWin++;
      end
      prevClk = micClk;
      if (cyc == 15625) firstRun = 0;
      if (sampleValid && prevValid) badWidth++;
      if (!sampleValid && sampleOut != prevOut) badHold++;
      if (sampleValid) begin
        validCount++;
        lastSample = sampleOut;
        if (lastValid < 0) firstValidCyc = cyc;
        else begin
          iv2 = iv1; iv1 = iv0; iv0 = cyc - lastValid; ivN++;
          if (iv0 != 2083 && iv0 != 2084) badGap++;
          if (ivN >= 3 && (iv0 + iv1 + iv2) != 6250) badSum++;
        end
        lastValid = cyc;
      end
      prevValid = sampleValid;
      prevOut = sampleOut;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitValids(input int n);
    int target = validCount + n;
    while (validCount < target) @(negedge clk);
  endtask

  // Stimulus table: {pattern, expected settled word}.
  localparam logic [19:0] VEC [6] = '{
    {4'b1111, 16'h4000},
    {4'b0000, 16'hC000},
    {4'b1010, 16'h0000},
    {4'b1100, 16'h0000},
    {4'b1110, 16'h2000},
    {4'b1000, 16'hE000}
  };

  function automatic string tagFor(input logic [15:0] e);
    if (e == 16'h4000 || e == 16'hC000) return "R5/R10";
    if (e == 16'h0000) return "R6";
    return "R7";
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    // R9: state held in reset
    check(micClk == 1'b0, "R9", "micClk in reset", int'(micClk), 0);
    check(sampleValid == 1'b0, "R9", "valid in reset", int'(sampleValid), 0);
    check(sampleOut == 16'h0, "R9", "word in reset", int'($signed(sampleOut)), 0);
    rst = 1'b0;

    foreach (VEC[i]) begin
      pattern = VEC[i][19:16];
      waitValids(8);
      check(lastSample == VEC[i][15:0], tagFor(VEC[i][15:0]), "settled word",
            int'($signed(lastSample)), int'($signed(VEC[i][15:0])));
      waitValids(1);
      check(lastSample == VEC[i][15:0], tagFor(VEC[i][15:0]), "next word",
            int'($signed(lastSample)), int'($signed(VEC[i][15:0])));
    end

    // Rate and timing checks gathered over the whole run.
    check(badClk == 0, "R1", "bit clock gaps outside 32..33", badClk, 0);
    check(risesWin == 480, "R2", "rises in 15625 cycles", risesWin, 480);
    check(badGap == 0, "R3", "valid intervals outside 2083..2084", badGap, 0);
    check(badWidth == 0, "R3", "valid wider than one cycle", badWidth, 0);
    check(badSum == 0, "R4", "three-interval sums not 6250", badSum, 0);
    check(badHold == 0, "R8", "word changed without valid", badHold, 0);
    check(validCount > 50, "R3", "valid pulses seen", validCount, 54);

    // R9: reset in the middle of a run
    repeat (700) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(sampleOut == 16'h0, "R9", "word cleared by reset", int'($signed(sampleOut)), 0);
    check(sampleValid == 1'b0, "R9", "valid cleared by reset", int'(sampleValid), 0);
    check(micClk == 1'b0, "R9", "micClk cleared by reset", int'(micClk), 0);
    pattern = 4'b1111;
    rst = 1'b0;
    waitValids(1);
    check(firstValidCyc >= 2060 && firstValidCyc <= 2080, "R9",
          "first valid after release", firstValidCyc, 2069);
    waitValids(7);
    check(lastSample == 16'h4000, "R10", "full scale after restart",
          int'($signed(lastSample)), 16384);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule